// File: doc/BRIEF.md
# Masked Time-Compare Event Pulse Generator

This block turns one selected event source into a timed output pulse. The source can be a match of the current date and time against a target, or an edge on one of thirty external lines. A single 32-bit configuration word holds every setting. Each time field (year, day, hour, minute, second, microsecond) has its own compare enable, so a match can ignore any subset of fields, for example to fire once per minute at a fixed second.

Pulse lengths are counted on a one-microsecond tick input. An event may require arming by a global start trigger and may be disarmed by a global stop trigger. It can run once and then clear its own enable bit, or fire again on every later occurrence. In dual mode an event produces two pulses, and each pulse can raise a one-cycle interrupt strobe.

Top module: `time_event_pulser`

## Requirements
- R1: After reset, evt_pulse, irq_sub0, irq_sub1 and evt_enabled are all 0.
- R2: A write (cfg_we=1) loads cfg_wdata as the configuration word. The bit positions are: 31 enable, 28 stop disarm, 27 second-pulse IRQ enable, 26 first-pulse IRQ enable, 25 dual, 24 repeat, 23:20 length code, 17 start arm, 11..6 compare enables for year, day, hour, minute, second and microsecond (bit 11 is year, bit 6 is microsecond), 5 edge, 4:0 source. Bits 30:29, 19:18 and 16:12 are ignored. evt_enabled shows bit 31 from the cycle after the write. A write cancels any pulse in progress, so evt_pulse is 0 the cycle after it, and the write also clears the armed state.
- R3: The source codes are:
  - Code 0 never fires.
  - Code 1 is the time match.
  - Codes 2 to 31 select src_line[code-2]. Codes 2 to 7 always act on the rising edge. Codes 8 to 31 act on the rising edge when bit 5 is 1 and on the falling edge when bit 5 is 0.
  - An accepted occurrence raises evt_pulse in the cycle after it is sampled.
- R4: For length codes 0 to 14, each pulse stays high for exactly (code+1)×60 us_tick cycles. Code 15 gives exactly 1000 us_tick cycles.
- R5: A time field takes part in the match only when its compare bit is set. A masked field with an unequal value does not prevent a match. A match fires on the us_tick where it first becomes true. It does not fire again while it stays true.
- R6: With bit 17 set, occurrences are ignored until a start_trig arrives while the event is enabled.
- R7: With bit 28 set, start_trig arms and a later stop_trig disarms the event, after which occurrences are ignored. If both triggers arrive in the same cycle, the event ends up disarmed.
- R8: With bit 24 clear, bit 31 clears itself in the cycle in which the last pulse ends, and later occurrences are ignored.
- R9: With bit 24 set, bit 31 stays set and every later occurrence fires again.
- R10: With bit 25 set, a second pulse of the same length follows the first one after a low gap of the same length in us_tick cycles.
- R11: irq_sub0 is a one-cycle strobe in the first cycle of the first pulse when bit 26 is set. irq_sub1 is a one-cycle strobe in the first cycle of the second pulse when bit 27 is set and dual is selected.
- R12: Occurrences that arrive while an event is in progress, including the gap, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word |
| us_tick | input | 1 | One-cycle strobe every microsecond |
| start_trig | input | 1 | Global start trigger |
| stop_trig | input | 1 | Global stop trigger |
| src_line | input | 30 | External source lines, selected by codes 2 to 31 |
| cur_year | input | YEAR_W | Current year |
| cur_day | input | DAY_W | Current day |
| cur_hour | input | HOUR_W | Current hour |
| cur_min | input | MIN_W | Current minute |
| cur_sec | input | SEC_W | Current second |
| cur_us | input | US_W | Current microsecond |
| tgt_year | input | YEAR_W | Target year |
| tgt_day | input | DAY_W | Target day |
| tgt_hour | input | HOUR_W | Target hour |
| tgt_min | input | MIN_W | Target minute |
| tgt_sec | input | SEC_W | Target second |
| tgt_us | input | US_W | Target microsecond |
| evt_pulse | output | 1 | Event pulse |
| irq_sub0 | output | 1 | First-pulse interrupt strobe |
| irq_sub1 | output | 1 | Second-pulse interrupt strobe |
| evt_enabled | output | 1 | Current value of the enable bit |

## Verification
The assertions check four things on every cycle:
- An interrupt strobe lasts one cycle and lands only on a rising pulse edge.
- A pulse starts only while the event is enabled.
- A self-clear of the enable bit coincides with the end of a pulse.
- Every completed pulse spans between 60 and 1000 ticks.

Only the bench scenarios can show the exact length for each code, the dual-mode gap, and the edge polarity for each source code. They also cover field masking, fire-once behaviour of a sustained match, the arming order of the start and stop triggers, and the discarding of occurrences while busy.

// File: rtl/time_event_pulser.sv
module time_event_pulser #(
  parameter int YEAR_W  = 7,
  parameter int DAY_W   = 9,
  parameter int HOUR_W  = 5,
  parameter int MIN_W   = 6,
  parameter int SEC_W   = 6,
  parameter int US_W    = 20,
  parameter int UNIT_US = 60,
  parameter int LONG_US = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  input  logic              us_tick,
  input  logic              start_trig,
  input  logic              stop_trig,
  input  logic [29:0]       src_line,
  input  logic [YEAR_W-1:0] cur_year,
  input  logic [DAY_W-1:0]  cur_day,
  input  logic [HOUR_W-1:0] cur_hour,
  input  logic [MIN_W-1:0]  cur_min,
  input  logic [SEC_W-1:0]  cur_sec,
  input  logic [US_W-1:0]   cur_us,
  input  logic [YEAR_W-1:0] tgt_year,
  input  logic [DAY_W-1:0]  tgt_day,
  input  logic [HOUR_W-1:0] tgt_hour,
  input  logic [MIN_W-1:0]  tgt_min,
  input  logic [SEC_W-1:0]  tgt_sec,
  input  logic [US_W-1:0]   tgt_us,
  output logic              evt_pulse,
  output logic              irq_sub0,
  output logic              irq_sub1,
  output logic              evt_enabled
);
  localparam int CW = $clog2(LONG_US + 1);

  typedef enum logic [1:0] {S_IDLE, S_P1, S_GAP, S_P2} state_t;

  state_t        state;
  logic [31:0]   cfg;
  logic [CW-1:0] cnt;
  logic          armed, match_q, line_q;

  wire [4:0]  code  = cfg[4:0];
  wire [3:0]  lcode = cfg[23:20];
  wire [31:0] lines = {src_line, 2'b00};
  wire        line  = lines[code];

  logic unused_cfg;
  assign unused_cfg = ^{cfg[30:29], cfg[19:18], cfg[16:12]};

  wire [5:0] fld_eq = {cur_year == tgt_year, cur_day == tgt_day, cur_hour == tgt_hour,
                       cur_min == tgt_min, cur_sec == tgt_sec, cur_us == tgt_us};
  wire t_match = &(fld_eq | ~cfg[11:6]);
  wire t_evt   = us_tick & t_match & ~match_q;

  wire rising  = (code < 5'd8) | cfg[5];
  wire ext_evt = (code >= 5'd2) & (rising ? (line & ~line_q) : (~line & line_q));
  wire occur   = (code == 5'd1) ? t_evt : ext_evt;
  wire ready   = cfg[31] & (~cfg[17] | armed);
  wire fire    = ready & occur & (state == S_IDLE);

  wire [CW-1:0] plen = (lcode == 4'd15) ? CW'(LONG_US) : CW'((int'(lcode) + 1) * UNIT_US);
  wire          last = us_tick & (cnt == plen - CW'(1));

  assign evt_pulse   = (state == S_P1) | (state == S_P2);
  assign evt_enabled = cfg[31];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cfg      <= '0;
      cnt      <= '0;
      armed    <= 1'b0;
      match_q  <= 1'b0;
      line_q   <= 1'b0;
      irq_sub0 <= 1'b0;
      irq_sub1 <= 1'b0;
    end else begin
      irq_sub0 <= 1'b0;
      irq_sub1 <= 1'b0;
      if (us_tick) match_q <= t_match;
      line_q <= cfg_we ? lines[cfg_wdata[4:0]] : line;
      if (cfg_we) begin
        cfg   <= cfg_wdata;
        armed <= 1'b0;
        state <= S_IDLE;
        cnt   <= '0;
      end else begin
        if (cfg[17] & cfg[31] & start_trig) armed <= 1'b1;
        if (cfg[28] & stop_trig) armed <= 1'b0;
        case (state)
          S_IDLE: if (fire) begin
            state    <= S_P1;
            cnt      <= '0;
            irq_sub0 <= cfg[26];
          end
          S_P1: if (last) begin
            cnt <= '0;
            if (cfg[25]) state <= S_GAP;
            else begin
              state <= S_IDLE;
              if (!cfg[24]) cfg[31] <= 1'b0;
            end
          end else if (us_tick) cnt <= cnt + CW'(1);
          S_GAP: if (last) begin
            cnt      <= '0;
            state    <= S_P2;
            irq_sub1 <= cfg[27];
          end else if (us_tick) cnt <= cnt + CW'(1);
          S_P2: if (last) begin
            cnt   <= '0;
            state <= S_IDLE;
            if (!cfg[24]) cfg[31] <= 1'b0;
          end else if (us_tick) cnt <= cnt + CW'(1);
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module time_event_pulser_chk #(
  parameter int UNIT_US = 60,
  parameter int LONG_US = 1000
) (
  input logic clk,
  input logic rst_n,
  input logic cfg_we,
  input logic us_tick,
  input logic evt_pulse,
  input logic irq_sub0,
  input logic irq_sub1,
  input logic evt_enabled
);
  localparam int KW = $clog2(LONG_US + 2);
  logic [KW-1:0] hi_ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_ticks <= '0;
    else if (!evt_pulse) hi_ticks <= '0;
    else if (us_tick) hi_ticks <= hi_ticks + KW'(1);
  end

  p_irq0_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_sub0 |=> !irq_sub0);
  p_irq0_on_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_sub0 |-> (evt_pulse && !$past(evt_pulse)));
  p_irq1_on_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_sub1 |-> (evt_pulse && !$past(evt_pulse)));
  p_irq_apart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_sub0 && irq_sub1));
  p_fire_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_pulse) |-> $past(evt_enabled));
  p_autoclear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(evt_enabled) && !$past(cfg_we)) |-> $fell(evt_pulse));
  p_len_bounds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(evt_pulse) && !$past(cfg_we)) |->
      ($past(us_tick) && (int'($past(hi_ticks)) + 1 >= UNIT_US)
       && (int'($past(hi_ticks)) + 1 <= LONG_US)));
endmodule

bind time_event_pulser time_event_pulser_chk #(.UNIT_US(UNIT_US), .LONG_US(LONG_US)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .us_tick(us_tick), .evt_pulse(evt_pulse),
  .irq_sub0(irq_sub0), .irq_sub1(irq_sub1), .evt_enabled(evt_enabled));

// File: tb/tb_time_event_pulser.sv
module tb_time_event_pulser;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic us_tick = 1'b0, start_trig = 1'b0, stop_trig = 1'b0;
  logic [29:0] src_line = '0;
  logic [6:0]  cur_year = 7'd20, tgt_year = 7'd99;
  logic [8:0]  cur_day = 9'd100, tgt_day = 9'd1;
  logic [4:0]  cur_hour = 5'd3, tgt_hour = 5'd4;
  logic [5:0]  cur_min = 6'd5, tgt_min = 6'd5;
  logic [5:0]  cur_sec = 6'd9, tgt_sec = 6'd10;
  logic [19:0] cur_us = 20'd1234, tgt_us = 20'd0;
  logic evt_pulse, irq_sub0, irq_sub1, evt_enabled;

  int checks = 0, errors = 0;
  int rises = 0, hi_ticks = 0, gap_ticks = 0, irq0_n = 0, irq1_n = 0;
  logic prev_pulse = 1'b0, clr_req = 1'b0;

  time_event_pulser dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .us_tick(us_tick),
    .start_trig(start_trig), .stop_trig(stop_trig), .src_line(src_line),
    .cur_year(cur_year), .cur_day(cur_day), .cur_hour(cur_hour), .cur_min(cur_min),
    .cur_sec(cur_sec), .cur_us(cur_us), .tgt_year(tgt_year), .tgt_day(tgt_day),
    .tgt_hour(tgt_hour), .tgt_min(tgt_min), .tgt_sec(tgt_sec), .tgt_us(tgt_us),
    .evt_pulse(evt_pulse), .irq_sub0(irq_sub0), .irq_sub1(irq_sub1), .evt_enabled(evt_enabled));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    @(posedge clk); #1 us_tick = ~us_tick;
  end

  always @(negedge clk) begin
    if (clr_req) begin
      rises = 0; hi_ticks = 0; gap_ticks = 0; irq0_n = 0; irq1_n = 0;
    end else begin
      if (evt_pulse && !prev_pulse) rises = rises + 1;
      if (evt_pulse && us_tick) hi_ticks = hi_ticks + 1;
      if (!evt_pulse && us_tick && rises == 1) gap_ticks = gap_ticks + 1;
      if (irq_sub0) irq0_n = irq0_n + 1;
      if (irq_sub1) irq1_n = irq1_n + 1;
    end
    prev_pulse = evt_pulse;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors = errors + 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit en, input bit spte, input bit i1, input bit i0,
      input bit dbl, input bit rpt, input logic [3:0] lc, input bit sta,
      input logic [5:0] cmp, input bit edg, input logic [4:0] src);
    return {en, 2'b11, spte, i1, i0, dbl, rpt, lc, 2'b00, sta, 5'b10101, cmp, edg, src};
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_counts();
    @(negedge clk); clr_req = 1'b1;
    @(negedge clk); clr_req = 1'b0;
    cyc(1);
  endtask

  task automatic wr_cfg(input logic [31:0] w);
    @(posedge clk); #1 cfg_we = 1'b1; cfg_wdata = w;
    @(posedge clk); #1 cfg_we = 1'b0;
  endtask

  task automatic pulse_line(input int idx);
    src_line[idx] = 1'b1;
    cyc(3);
    src_line[idx] = 1'b0;
    cyc(1);
  endtask

  task automatic t_reset();
    check(evt_pulse == 0, "R1 pulse", int'(evt_pulse), 0);
    check(irq_sub0 == 0 && irq_sub1 == 0, "R1 irq", int'({irq_sub1, irq_sub0}), 0);
    check(evt_enabled == 0, "R1 enabled", int'(evt_enabled), 0);
  endtask

  task automatic t_ext_rise_oneshot();
    wr_cfg(mk(1, 0, 0, 0, 0, 0, 4'd0, 0, 6'd0, 0, 5'd3));
    check(evt_enabled == 1, "R2 enabled after write", int'(evt_enabled), 1);
    clear_counts();
    pulse_line(1);
    check(rises == 1 && evt_pulse == 1, "R3 rising edge code 3", rises, 1);
    cyc(200);
    check(hi_ticks == 60, "R4 code 0 length", hi_ticks, 60);
    check(rises == 1, "R3 no falling fire", rises, 1);
    check(evt_enabled == 0, "R8 auto clear", int'(evt_enabled), 0);
    pulse_line(1);
    cyc(10);
    check(rises == 1, "R8 ignored after clear", rises, 1);
  endtask

  task automatic t_ext_fall_repeat();
    wr_cfg(mk(1, 0, 0, 0, 0, 1, 4'd0, 0, 6'd0, 0, 5'd9));
    clear_counts();
    src_line[7] = 1'b1;
    cyc(20);
    check(rises == 0, "R3 rising ignored on falling select", rises, 0);
    src_line[7] = 1'b0;
    cyc(200);
    check(rises == 1, "R3 falling edge code 9", rises, 1);
    check(evt_enabled == 1, "R9 stays enabled", int'(evt_enabled), 1);
    src_line[7] = 1'b1; cyc(3); src_line[7] = 1'b0;
    cyc(200);
    check(rises == 2 && hi_ticks == 120, "R9 refire", rises, 2);
  endtask

  task automatic t_lengths();
    wr_cfg(mk(1, 0, 0, 0, 0, 0, 4'd4, 0, 6'd0, 0, 5'd2));
    clear_counts();
    pulse_line(0);
    cyc(700);
    check(hi_ticks == 300, "R4 code 4 length", hi_ticks, 300);
    wr_cfg(mk(1, 0, 0, 0, 0, 0, 4'd15, 0, 6'd0, 0, 5'd2));
    clear_counts();
    pulse_line(0);
    cyc(2100);
    check(hi_ticks == 1000, "R4 code 15 length", hi_ticks, 1000);
  endtask

  task automatic t_code0();
    wr_cfg(mk(1, 0, 0, 0, 0, 1, 4'd0, 0, 6'd0, 1, 5'd0));
    clear_counts();
    src_line = '1; cyc(5); src_line = '0; cyc(10);
    check(rises == 0, "R3 code 0 silent", rises, 0);
  endtask

  task automatic t_time_match();
    cur_sec = 6'd9;
    wr_cfg(mk(1, 0, 0, 0, 0, 1, 4'd0, 0, 6'b000110, 0, 5'd1));
    clear_counts();
    cyc(10);
    check(rises == 0, "R5 no match yet", rises, 0);
    cur_sec = 6'd10;
    cyc(10);
    check(rises == 1, "R5 masked fields ignored", rises, 1);
    cyc(300);
    check(rises == 1, "R5 no refire while true", rises, 1);
    cur_sec = 6'd11; cyc(10);
    cur_sec = 6'd10; cyc(10);
    check(rises == 2, "R5 refire on new match", rises, 2);
    cyc(300);
    wr_cfg(mk(1, 0, 0, 0, 0, 1, 4'd0, 0, 6'b000111, 0, 5'd1));
    clear_counts();
    cur_sec = 6'd11; cyc(10);
    cur_sec = 6'd10; cyc(10);
    check(rises == 0, "R5 enabled field blocks", rises, 0);
  endtask

  task automatic t_arming();
    wr_cfg(mk(1, 1, 0, 0, 0, 1, 4'd0, 1, 6'd0, 0, 5'd2));
    clear_counts();
    pulse_line(0); cyc(5);
    check(rises == 0, "R6 unarmed ignored", rises, 0);
    start_trig = 1'b1; cyc(1); start_trig = 1'b0; cyc(2);
    pulse_line(0); cyc(200);
    check(rises == 1, "R6 armed fires", rises, 1);
    stop_trig = 1'b1; cyc(1); stop_trig = 1'b0; cyc(2);
    pulse_line(0); cyc(10);
    check(rises == 1, "R7 disarmed ignored", rises, 1);
    start_trig = 1'b1; stop_trig = 1'b1; cyc(1);
    start_trig = 1'b0; stop_trig = 1'b0; cyc(2);
    pulse_line(0); cyc(10);
    check(rises == 1, "R7 simultaneous triggers", rises, 1);
  endtask

  task automatic t_dual();
    wr_cfg(mk(1, 0, 1, 1, 1, 0, 4'd0, 0, 6'd0, 0, 5'd2));
    clear_counts();
    pulse_line(0);
    cyc(500);
    check(rises == 2, "R10 two pulses", rises, 2);
    check(hi_ticks == 120, "R10 both lengths", hi_ticks, 120);
    check(gap_ticks == 60, "R10 gap length", gap_ticks, 60);
    check(irq0_n == 1 && irq1_n == 1, "R11 both irqs", irq0_n * 10 + irq1_n, 11);
    check(evt_enabled == 0, "R8 clear after second", int'(evt_enabled), 0);
    wr_cfg(mk(1, 0, 1, 1, 0, 0, 4'd0, 0, 6'd0, 0, 5'd2));
    clear_counts();
    pulse_line(0);
    cyc(200);
    check(irq0_n == 1 && irq1_n == 0, "R11 single mode irq", irq0_n * 10 + irq1_n, 10);
  endtask

  task automatic t_busy_abort();
    wr_cfg(mk(1, 0, 0, 0, 1, 1, 4'd0, 0, 6'd0, 0, 5'd2));
    clear_counts();
    pulse_line(0); cyc(20);
    pulse_line(0); cyc(150);
    pulse_line(0);
    cyc(300);
    check(rises == 2 && hi_ticks == 120, "R12 busy ignored", rises, 2);
    check(evt_enabled == 1, "R9 dual repeat enabled", int'(evt_enabled), 1);
    wr_cfg(mk(1, 0, 0, 0, 0, 0, 4'd15, 0, 6'd0, 0, 5'd2));
    pulse_line(0); cyc(20);
    check(evt_pulse == 1, "R2 pulse before abort", int'(evt_pulse), 1);
    wr_cfg(32'h0);
    check(evt_pulse == 0, "R2 write aborts", int'(evt_pulse), 0);
    check(evt_enabled == 0, "R2 enable written 0", int'(evt_enabled), 0);
  endtask

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_ext_rise_oneshot();
    t_ext_fall_repeat();
    t_lengths();
    t_code0();
    t_time_match();
    t_arming();
    t_dual();
    t_busy_abort();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule